// File: doc/BRIEF.md
# Two-Phase Stepper Microstep Sequencer

This block produces the drive pattern for both windings of a two-phase bipolar stepper motor. For each winding it gives a direction bit and a two-bit current-level code. A power bridge and an analog current regulator, which sit outside the block, turn these into coil current. Every accepted step strobe moves the motor one position around an electrical circle. The circle has four positions at full resolution, eight at half resolution and sixteen at quarter resolution.

Internally the block keeps a single position on the sixteen-entry quarter circle. Half resolution moves this position by two entries per step, and full resolution moves it by four. A resolution change therefore keeps the rotor angle: the position drops to the nearest table entry at or below it in the new table. The block also reports the step index in units of the selected table. The levels are held at zero until the motor supply is reported good. Steps are ignored while the block is disabled or the supply is not good.

Top module: `stepper_seq`

## Requirements
- R1: After reset the step index is 0, the resolution register holds full (00), and both level codes read 00 until `pwr_ok_i` has been sampled high.
- R2: The level code {IN1,IN2} means 11 = 100 %, 10 = 71 %, 01 = 38 %, 00 = 0 %. A phase bit of 1 means positive current and 0 means negative current.
- R3: At full resolution (`res_i` = 00) the channels are (A,B) = (+100,+100), (-100,+100), (-100,-100), (+100,-100) for indices 0 to 3. A counting step advances the index by one, modulo 4.
- R4: At half resolution (`res_i` = 01) even index 2k gives full state k. The odd indices 1, 3, 5 and 7 give (0,+100), (-100,0), (0,-100) and (+100,0). Only the codes 11 and 00 appear.
- R5: At quarter resolution (`res_i` = 10 or 11) channel A over indices 0 to 15 is 71, 38, 0, -38, -71, -100, -100, -100, -71, -38, 0, 38, 71, 100, 100, 100 percent. Channel B at index i equals channel A at index (i+12) mod 16.
- R6: With `dir_i` = 1 a step increments the index. With `dir_i` = 0 it decrements the index. Both wrap modulo the table length.
- R7: Exactly one step is taken for each rising edge of `step_i`. A strobe held high does not step again. The new state appears at the outputs after the clock edge that samples the rise.
- R8: While `enable_i` is low, rising edges of `step_i` leave the index and the outputs unchanged.
- R9: One clock after `pwr_ok_i` is sampled low, both level codes read 00. Steps taken while it is low are ignored. The pattern for the held position returns one clock after it is sampled high again.
- R10: On a resolution change the quarter position drops to the nearest entry at or below it in the new table. The index is reported in the new table's units, for example quarter 7 becomes half 3, then full 1, then quarter 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step strobe, acted on at its rising edge |
| dir_i | input | 1 | 1 = count up (clockwise), 0 = count down |
| res_i | input | 2 | 00 full, 01 half, 1x quarter resolution |
| enable_i | input | 1 | Steps accepted only when high |
| pwr_ok_i | input | 1 | Motor supply in range |
| a_phase_o | output | 1 | Channel A current direction |
| a_lvl_o | output | 2 | Channel A level code {IN1,IN2} |
| b_phase_o | output | 1 | Channel B current direction |
| b_lvl_o | output | 2 | Channel B level code {IN1,IN2} |
| idx_o | output | 4 | Step index in units of the current table |

## Verification
Several properties are checked on every cycle. The internal position always sits on an entry of the selected table. An accepted step moves it by exactly the resolution stride in the commanded direction. Without an accepted step or a resolution change it does not move. Coarse resolutions never emit the 71 % or 38 % codes, and a supply fault forces both levels to zero. Only the bench scenarios can show that the full sequence of signed winding currents matches the reference circle in both directions at all three resolutions. The same holds for the quarter-turn offset between channels and for the specific positions chosen when the resolution changes.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int unsigned POS_W   = 4;
  localparam int unsigned QTR_LEN = 1 << POS_W;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned NCH     = 2;
  localparam int unsigned CH_OFFS = QTR_LEN - QTR_LEN / 4;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_0   = 2'b00;
  localparam lvl_t LVL_38  = 2'b01;
  localparam lvl_t LVL_71  = 2'b10;
  localparam lvl_t LVL_100 = 2'b11;

  // resolution select -> log2 of quarter entries per step
  function automatic logic [1:0] res_shift(input logic [1:0] res);
    case (res)
      2'b00:   return 2'd2;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic pos_t res_stride(input logic [1:0] res);
    return pos_t'(1) << res_shift(res);
  endfunction

  // drop a quarter position to the table entry at or below it
  function automatic pos_t pos_align(input pos_t p, input logic [1:0] res);
    pos_t mask;
    mask = {POS_W{1'b1}} << res_shift(res);
    return p & mask;
  endfunction

  // magnitude of the quarter circle, repeats every half turn
  function automatic lvl_t qtr_mag(input pos_t p);
    case (p[POS_W-2:0])
      3'd0, 3'd4: return LVL_71;
      3'd1, 3'd3: return LVL_38;
      3'd2:       return LVL_0;
      default:    return LVL_100;
    endcase
  endfunction

  // negative half of the quarter circle
  function automatic logic qtr_neg(input pos_t p);
    return (p >= pos_t'(3)) && (p <= pos_t'(9));
  endfunction
endpackage

// File: rtl/stepseq_edge.sv
module stepseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/stepseq_index.sv
module stepseq_index
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       dir_i,
  input  logic [1:0] res_i,
  output pos_t       pos_o,
  output logic [1:0] res_o
);
  pos_t       pos_q;
  logic [1:0] res_q;
  pos_t       pos_al;
  pos_t       pos_n;

  always_comb begin
    pos_al = pos_align(pos_q, res_i);
    pos_n  = pos_al;
    if (adv_i) begin
      if (dir_i) pos_n = pos_al + res_stride(res_i);
      else       pos_n = pos_al - res_stride(res_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      res_q <= 2'b00;
    end else begin
      pos_q <= pos_n;
      res_q <= res_i;
    end
  end

  assign pos_o = pos_q;
  assign res_o = res_q;
endmodule

// File: rtl/stepseq_level.sv
module stepseq_level
  import stepseq_pkg::*;
#(
  parameter int unsigned OFFSET = 0
) (
  input  pos_t       pos_i,
  input  logic [1:0] res_i,
  input  logic       pwr_ok_i,
  output logic       phase_o,
  output lvl_t       lvl_o
);
  pos_t p;
  lvl_t mag;

  always_comb begin
    p   = pos_i + pos_t'(OFFSET);
    mag = qtr_mag(p);
    if (res_shift(res_i) != 2'd0 && mag != LVL_0) mag = LVL_100;
    lvl_o   = pwr_ok_i ? mag : LVL_0;
    phase_o = ~qtr_neg(p);
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic [1:0] res_i,
  input  logic       enable_i,
  input  logic       pwr_ok_i,
  output logic       a_phase_o,
  output logic [1:0] a_lvl_o,
  output logic       b_phase_o,
  output logic [1:0] b_lvl_o,
  output logic [3:0] idx_o
);
  logic       step_rise;
  logic       step_ok;
  logic       pwr_ok_q;
  pos_t       pos_q;
  logic [1:0] res_q;
  logic [NCH-1:0] ch_phase;
  lvl_t       ch_lvl [NCH];

  stepseq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_i(step_i), .rise_o(step_rise)
  );

  assign step_ok = step_rise & enable_i & pwr_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_ok_q <= 1'b0;
    else        pwr_ok_q <= pwr_ok_i;
  end

  stepseq_index u_index (
    .clk(clk), .rst_n(rst_n), .adv_i(step_ok), .dir_i(dir_i),
    .res_i(res_i), .pos_o(pos_q), .res_o(res_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    stepseq_level #(.OFFSET(g * CH_OFFS)) u_lvl (
      .pos_i(pos_q), .res_i(res_q), .pwr_ok_i(pwr_ok_q),
      .phase_o(ch_phase[g]), .lvl_o(ch_lvl[g])
    );
  end

  assign a_phase_o = ch_phase[0];
  assign a_lvl_o   = ch_lvl[0];
  assign b_phase_o = ch_phase[1];
  assign b_lvl_o   = ch_lvl[1];
  assign idx_o     = pos_q >> res_shift(res_q);
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_ok,
  input logic       dir_i,
  input logic [1:0] res_i,
  input logic [1:0] res_q,
  input logic [3:0] pos_q,
  input logic       pwr_ok_q,
  input logic [1:0] a_lvl_o,
  input logic [1:0] b_lvl_o
);
  logic [3:0] strd;
  assign strd = (res_i == 2'b00) ? 4'd4 : (res_i == 2'b01) ? 4'd2 : 4'd1;

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok && dir_i && (res_i == res_q) |=> pos_q == 4'($past(pos_q) + $past(strd)));

  // R6
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok && !dir_i && (res_i == res_q) |=> pos_q == 4'($past(pos_q) - $past(strd)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ok && (res_i == res_q) |=> $stable(pos_q));

  // R9
  pwr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_q |-> (a_lvl_o == 2'b00) && (b_lvl_o == 2'b00));

  // R4
  coarse_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[1] == 1'b0) |-> (a_lvl_o[1] == a_lvl_o[0]) && (b_lvl_o[1] == b_lvl_o[0]));

  // R10
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_q == 2'b00) |-> pos_q[1:0] == 2'b00) and ((res_q == 2'b01) |-> pos_q[0] == 1'b0));
endmodule

bind stepper_seq stepper_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step_ok(step_ok), .dir_i(dir_i), .res_i(res_i),
  .res_q(res_q), .pos_q(pos_q), .pwr_ok_q(pwr_ok_q),
  .a_lvl_o(a_lvl_o), .b_lvl_o(b_lvl_o)
);

// File: tb/stepper_seq_bench.sv
module stepper_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, dir_i = 1'b1, enable_i = 1'b0, pwr_ok_i = 1'b0;
  logic [1:0] res_i = 2'b00;
  logic a_phase_o, b_phase_o;
  logic [1:0] a_lvl_o, b_lvl_o;
  logic [3:0] idx_o;

  int checks = 0;
  int errors = 0;
  int qpos = 0;   // bench model: quarter position 0..15

  always #5 clk = ~clk;

  stepper_seq u_stepper_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i), .res_i(res_i),
    .enable_i(enable_i), .pwr_ok_i(pwr_ok_i), .a_phase_o(a_phase_o),
    .a_lvl_o(a_lvl_o), .b_phase_o(b_phase_o), .b_lvl_o(b_lvl_o), .idx_o(idx_o)
  );

  // R2: signed current rebuilt from a phase bit and level code
  function automatic int cur(input logic ph, input logic [1:0] lv);
    int m;
    case (lv)
      2'b11: m = 100;
      2'b10: m = 71;
      2'b01: m = 38;
      default: m = 0;
    endcase
    return ph ? m : -m;
  endfunction

  function automatic int qa(input int i);
    case (i % 16)
      0: return 71;   1: return 38;   2: return 0;    3: return -38;
      4: return -71;  5: return -100; 6: return -100; 7: return -100;
      8: return -71;  9: return -38;  10: return 0;   11: return 38;
      12: return 71;  13: return 100; 14: return 100; default: return 100;
    endcase
  endfunction

  function automatic int shift_of(input logic [1:0] r);
    return (r == 2'b00) ? 2 : (r == 2'b01) ? 1 : 0;
  endfunction

  function automatic int exp_cur(input int ch, input logic [1:0] r, input int idx);
    if (r == 2'b00) begin
      if (ch == 0) return (idx == 0 || idx == 3) ? 100 : -100;
      return (idx < 2) ? 100 : -100;
    end else if (r == 2'b01) begin
      if (idx % 2 == 0) return exp_cur(ch, 2'b00, idx / 2);
      case (idx)
        1: return (ch == 0) ? 0 : 100;
        3: return (ch == 0) ? -100 : 0;
        5: return (ch == 0) ? 0 : -100;
        default: return (ch == 0) ? 100 : 0;
      endcase
    end
    return (ch == 0) ? qa(idx) : qa(idx + 12);
  endfunction

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input bit powered);
    int idx;
    idx = qpos >> shift_of(res_i);
    check_int({tag, " idx"}, int'(idx_o), idx);
    check_int({tag, " A"}, cur(a_phase_o, a_lvl_o), powered ? exp_cur(0, res_i, idx) : 0);
    check_int({tag, " B"}, cur(b_phase_o, b_lvl_o), powered ? exp_cur(1, res_i, idx) : 0);
  endtask

  task automatic pulse(input bit counts);
    @(negedge clk) step_i = 1'b1;
    @(negedge clk) step_i = 1'b0;
    if (counts) qpos = (qpos + (dir_i ? 1 : -1) * (1 << shift_of(res_i)) + 16) % 16;
  endtask

  task automatic set_res(input logic [1:0] r);
    @(negedge clk) res_i = r;
    qpos = (qpos >> shift_of(r)) << shift_of(r);
    @(negedge clk);
  endtask

  // R3 R4 R5 R6: walk a table one and a half turns in one direction
  task automatic walk(input logic [1:0] r, input logic d, input string tag);
    int n;
    set_res(r);
    dir_i = d;
    n = (16 >> shift_of(r)) + (8 >> shift_of(r));
    for (int k = 0; k < n; k++) begin
      pulse(1'b1);
      check_state(tag, 1'b1);
    end
  endtask

  // R7: held strobe steps once
  task automatic test_held;
    set_res(2'b01);
    dir_i = 1'b1;
    @(negedge clk) step_i = 1'b1;
    qpos = (qpos + 2) % 16;
    repeat (4) @(negedge clk);
    check_state("R7 held strobe", 1'b1);
    step_i = 1'b0;
    @(negedge clk);
    check_state("R7 after release", 1'b1);
  endtask

  // R8: disabled steps ignored
  task automatic test_disable;
    enable_i = 1'b0;
    pulse(1'b0);
    pulse(1'b0);
    check_state("R8 disabled", 1'b1);
    enable_i = 1'b1;
    pulse(1'b1);
    check_state("R8 re-enabled", 1'b1);
  endtask

  // R9: supply fault zeroes levels and blocks steps
  task automatic test_power;
    @(negedge clk) pwr_ok_i = 1'b0;
    @(negedge clk);
    check_state("R9 supply low", 1'b0);
    pulse(1'b0);
    check_state("R9 step while low", 1'b0);
    pwr_ok_i = 1'b1;
    @(negedge clk);
    check_state("R9 supply back", 1'b1);
  endtask

  // R10: rescale on resolution change
  task automatic test_rescale;
    set_res(2'b10);
    dir_i = 1'b1;
    while (qpos != 7) pulse(1'b1);
    check_state("R10 quarter 7", 1'b1);
    set_res(2'b01);
    check_int("R10 half idx", int'(idx_o), 3);
    check_state("R10 half", 1'b1);
    set_res(2'b00);
    check_int("R10 full idx", int'(idx_o), 1);
    check_state("R10 full", 1'b1);
    set_res(2'b11);
    check_int("R10 quarter idx", int'(idx_o), 4);
    check_state("R10 quarter", 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, levels zero before supply good
    check_state("R1 reset", 1'b0);
    pwr_ok_i = 1'b1;
    enable_i = 1'b1;
    @(negedge clk);
    check_state("R1 powered idx0", 1'b1);
    walk(2'b00, 1'b1, "R3 full cw");
    walk(2'b00, 1'b0, "R6 full ccw");
    walk(2'b01, 1'b1, "R4 half cw");
    walk(2'b01, 1'b0, "R6 half ccw");
    walk(2'b10, 1'b1, "R5 quarter cw");
    walk(2'b11, 1'b0, "R6 quarter ccw");
    test_held();
    test_disable();
    test_power();
    test_rescale();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule